// File: doc/BRIEF.md
# Halfword-Swapping DMA Address and Data Path

This block sits between a 16-bit peripheral and a 32-bit memory port. For every transfer the peripheral hands over a partial byte address, a byte count, a direction and a mode flag. The block forms the memory address by a bitwise OR of the partial address with a high base value; it does not add them. It then walks the transfer as a sequence of word beats on a request/ready memory port, each beat carrying byte enables for exactly the bytes it moves.

In pass-through mode the address, the count and the data bytes are used exactly as given. In swap mode the block clears the low bit of both the address and the count before starting. It exchanges the two bytes of every halfword on the data path, in both directions. Swap-mode writes to memory are also cut into chunks of at most `CHUNK_BYTES` bytes, and a marker flags the last beat of each chunk. A single-cycle done pulse marks the end of each transfer, and a busy flag tells the peripheral when a new transfer may be handed over.

Top module: `dma_hswap_xfer`

## Requirements
- R1: The address of the first beat is the word-aligned value of (`req_addr` OR `hi_base`), with `hi_base` sampled when the request is accepted. Overlapping set bits are merged and never carried. `mem_addr` always has its low log2(DW/8) bits at zero.
- R2: In pass-through mode (`req_swap`=0), the address and length are used unchanged and data bytes keep their lanes: `mem_wdata` equals `pw_data`, and read data is returned unswapped.
- R3: In swap mode (`req_swap`=1), bit 0 of the formed address and bit 0 of the length are cleared before the first beat. The transfer therefore moves length AND ~1 bytes starting at an even address.
- R4: In swap mode, byte lane i is data bits [8i+7:8i], and lanes 0 and 1 are exchanged, as are lanes 2 and 3. This holds for `mem_wdata` (from `pw_data`) and for `rd_data` (from `mem_rdata`).
- R5: Swap-mode writes to memory are split into chunks of at most 64 bytes (`CHUNK_BYTES`), counted from the transfer start. `mem_last` is 1 on the final beat of each chunk, and the address runs on contiguously into the next chunk. For reads and for pass-through writes, `mem_last` is 1 only on the final beat of the transfer.
- R6: Each beat moves n = min(bytes to the next word boundary, remaining bytes, bytes left in the chunk) bytes. `mem_be` bit i is 1 exactly for lanes addr mod 4 through addr mod 4 + n - 1, and is never all zero.
- R7: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. A request whose length is zero after masking raises `done` in the cycle after acceptance and issues no memory request.
- R8: A request is accepted only while `busy` is 0. A `req_valid` asserted while `busy` is 1 is ignored and starts no later transfer. `busy` is 1 from the cycle after acceptance until `done`.
- R9: For a read from memory, `rd_valid` is high in the cycle after each accepted beat. `rd_be` equals that beat's `mem_be`, and `rd_data` holds the (swapped or unswapped) `mem_rdata` with lanes outside `rd_be` forced to zero.
- R10: While `mem_req` is 1 and `mem_ready` is 0, `mem_addr`, `mem_be`, `mem_last` and `mem_we` hold their values. `pw_take` is 1 exactly when a write beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_base | input | AW | High base value ORed into the peripheral address |
| req_valid | input | 1 | Transfer request from the peripheral |
| req_addr | input | AW | Partial byte address |
| req_len | input | LW | Transfer length in bytes |
| req_swap | input | 1 | 1 = halfword byte swap mode, 0 = pass-through |
| req_to_mem | input | 1 | 1 = write to memory, 0 = read from memory |
| busy | output | 1 | Transfer in progress; requests are ignored |
| done | output | 1 | One-cycle pulse at transfer end |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Word-aligned beat address |
| mem_be | output | DW/8 | Byte enables of the beat |
| mem_last | output | 1 | Last beat of a chunk or transfer |
| mem_wdata | output | DW | Write data, swapped in swap mode |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| pw_data | input | DW | Peripheral write data for the current beat, lane aligned |
| pw_take | output | 1 | Current write beat consumed |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data toward the peripheral |
| rd_be | output | DW/8 | Lanes valid in rd_data |

## Verification
The bench sweeps both modes and both directions over eight address offsets, with a base that shares a set bit with the address. A design that added the base instead of ORing it would show a carried address. Lengths of zero, one, odd, and just below, at and above the 64-byte chunk size stress the swap-mode masking, where a missed clear would move an odd byte or start a beat at an odd lane. The same lengths stress the chunk boundaries, where a bad count would put `mem_last` on the wrong beat or let a beat straddle two chunks. Memory stalls are mixed in while a stray request is presented during busy cycles. A block that accepted it, or that moved its outputs during a stall, would show wrong beats or a spurious later transfer.

// File: rtl/dma_hswap_pkg.sv
package dma_hswap_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xfer_st_e;

endpackage

// File: rtl/dma_hswap_setup.sv
// Forms the starting address and effective length of a transfer.
module dma_hswap_setup #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] part_addr,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len_in,
    input  logic          swap_mode,
    output logic [AW-1:0] start_addr,
    output logic [LW-1:0] eff_len
);
    always_comb begin
        start_addr = part_addr | base;
        eff_len    = len_in;
        if (swap_mode) begin
            start_addr[0] = 1'b0;
            eff_len[0]    = 1'b0;
        end
    end
endmodule

// File: rtl/dma_hswap_lanes.sv
// Optional exchange of the two bytes inside each halfword of a data word.
module dma_hswap_lanes #(
    parameter int DW = 32
) (
    input  logic          swap_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int NH = DW / 16;

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign dout[16*h +: 8]     = swap_en ? din[16*h + 8 +: 8] : din[16*h +: 8];
        assign dout[16*h + 8 +: 8] = swap_en ? din[16*h +: 8]     : din[16*h + 8 +: 8];
    end
endmodule

// File: rtl/dma_hswap_beat.sv
// Sizes one memory beat: byte count, byte enables and end markers.
module dma_hswap_beat #(
    parameter int LW   = 16,
    parameter int NB   = 4,
    parameter int OFFW = 2,
    parameter int CW   = 7,
    parameter int NW   = OFFW + 1
) (
    input  logic [OFFW-1:0] off,
    input  logic [LW-1:0]   rem,
    input  logic [CW-1:0]   chunk_left,
    input  logic            chunked,
    output logic [NW-1:0]   nbytes,
    output logic [NB-1:0]   be,
    output logic            ends_xfer,
    output logic            ends_chunk
);
    logic [NW-1:0] room;

    always_comb begin
        room   = NW'(NB) - {1'b0, off};
        nbytes = room;
        if (int'(rem) < int'(nbytes)) begin
            nbytes = NW'(rem);
        end
        if (chunked && (int'(chunk_left) < int'(nbytes))) begin
            nbytes = NW'(chunk_left);
        end
        ends_xfer  = (int'(rem) == int'(nbytes));
        ends_chunk = chunked && (int'(chunk_left) == int'(nbytes));
    end

    for (genvar i = 0; i < NB; i++) begin : g_be
        assign be[i] = (int'(off) <= i) && (i < int'(off) + int'(nbytes));
    end
endmodule

// File: rtl/dma_hswap_xfer.sv
// Transfer sequencer: accepts requests, walks beats, returns read data.
module dma_hswap_xfer
    import dma_hswap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int DW          = 32,
    parameter int CHUNK_BYTES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   hi_base,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [LW-1:0]   req_len,
    input  logic            req_swap,
    input  logic            req_to_mem,
    output logic            busy,
    output logic            done,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic            mem_last,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [DW-1:0]   pw_data,
    output logic            pw_take,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic [DW/8-1:0] rd_be
);
    localparam int NB   = DW / 8;
    localparam int OFFW = $clog2(NB);
    localparam int NW   = OFFW + 1;
    localparam int CW   = $clog2(CHUNK_BYTES + 1);
    localparam logic [CW-1:0] CHUNK_INIT = CW'(CHUNK_BYTES);

    typedef struct packed {
        xfer_st_e       st;
        logic [AW-1:0]  addr;
        logic [LW-1:0]  rem;
        logic [CW-1:0]  chunk;
        logic           swap;
        logic           we;
        logic           done;
        logic           rd_valid;
        logic [DW-1:0]  rd_data;
        logic [NB-1:0]  rd_be;
    } xfer_state_t;

    xfer_state_t q, d;

    logic [AW-1:0] start_addr;
    logic [LW-1:0] eff_len;
    logic [NW-1:0] nbytes;
    logic [NB-1:0] be;
    logic          ends_xfer;
    logic          ends_chunk;
    logic          chunked;
    logic [DW-1:0] rd_swapped;
    logic [DW-1:0] lane_mask;

    assign chunked = q.swap && q.we;

    dma_hswap_setup #(.AW(AW), .LW(LW)) u_setup (
        .part_addr  (req_addr),
        .base       (hi_base),
        .len_in     (req_len),
        .swap_mode  (req_swap),
        .start_addr (start_addr),
        .eff_len    (eff_len)
    );

    dma_hswap_beat #(.LW(LW), .NB(NB), .OFFW(OFFW), .CW(CW), .NW(NW)) u_beat (
        .off        (q.addr[OFFW-1:0]),
        .rem        (q.rem),
        .chunk_left (q.chunk),
        .chunked    (chunked),
        .nbytes     (nbytes),
        .be         (be),
        .ends_xfer  (ends_xfer),
        .ends_chunk (ends_chunk)
    );

    dma_hswap_lanes #(.DW(DW)) u_wr_lanes (
        .swap_en (q.swap),
        .din     (pw_data),
        .dout    (mem_wdata)
    );

    dma_hswap_lanes #(.DW(DW)) u_rd_lanes (
        .swap_en (q.swap),
        .din     (mem_rdata),
        .dout    (rd_swapped)
    );

    for (genvar i = 0; i < NB; i++) begin : g_mask
        assign lane_mask[8*i +: 8] = {8{be[i]}};
    end

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.rd_valid = 1'b0;
        if (q.st == ST_IDLE) begin
            if (req_valid) begin
                if (eff_len == '0) begin
                    d.done = 1'b1;
                end else begin
                    d.st    = ST_RUN;
                    d.addr  = start_addr;
                    d.rem   = eff_len;
                    d.chunk = CHUNK_INIT;
                    d.swap  = req_swap;
                    d.we    = req_to_mem;
                end
            end
        end else if (mem_ready) begin
            d.addr = q.addr + AW'(nbytes);
            d.rem  = q.rem - LW'(nbytes);
            if (chunked) begin
                d.chunk = ends_chunk ? CHUNK_INIT : (q.chunk - CW'(nbytes));
            end
            if (!q.we) begin
                d.rd_valid = 1'b1;
                d.rd_data  = rd_swapped & lane_mask;
                d.rd_be    = be;
            end
            if (ends_xfer) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st == ST_RUN);
    assign done     = q.done;
    assign mem_req  = (q.st == ST_RUN);
    assign mem_we   = q.we;
    assign mem_addr = {q.addr[AW-1:OFFW], OFFW'(0)};
    assign mem_be   = be;
    assign mem_last = ends_xfer || ends_chunk;
    assign pw_take  = mem_req && q.we && mem_ready;
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign rd_be    = q.rd_be;

    // Swap-mode transfers stay halfword aligned on every beat (R3).
    assert_even_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q.swap) |-> (!q.addr[0] && !q.rem[0]));

    // Chunk budget stays within 1..CHUNK_BYTES and bounds each beat (R5).
    assert_chunk_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && chunked) |-> ((q.chunk != '0) && (q.chunk <= CHUNK_INIT)
                                  && (int'(nbytes) <= int'(q.chunk))));

    // Every beat moves at least one byte (R6).
    assert_be_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != '0));

    // Done only appears with the sequencer idle (R7).
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Busy only starts from a request seen in the previous cycle (R8).
    assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // Read data follows an accepted read beat (R9).
    assert_rd_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_req && mem_ready && !mem_we));

    // A stalled beat holds its request fields (R10).
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                     && $stable(mem_last) && $stable(mem_we)));
endmodule

// File: tb/dma_hswap_xfer_tb.sv
module dma_hswap_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hi_base = 32'h8000_1004;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_swap = 1'b0;
    logic        req_to_mem = 1'b0;
    logic        busy, done, mem_req, mem_we, mem_last, pw_take, rd_valid;
    logic [31:0] mem_addr, mem_wdata, rd_data;
    logic [3:0]  mem_be, rd_be;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] pw_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_hswap_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .hi_base(hi_base),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .req_swap(req_swap), .req_to_mem(req_to_mem),
        .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_last(mem_last), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .pw_data(pw_data), .pw_take(pw_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_be(rd_be)
    );

    function automatic logic [31:0] sw16(input logic [31:0] x);
        return {x[23:16], x[31:24], x[7:0], x[15:8]};
    endfunction

    function automatic logic [31:0] bmask(input logic [3:0] b);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (b[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_xfer(input logic [31:0] a_in, input int len_in,
                            input bit sw, input bit dr);
        logic [31:0] ea, pw, rdv, exp_rd;
        logic [3:0]  ebe;
        int el, ch, kb, off, n;
        bit last;
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle before request", 32'(busy), 0);
        req_addr = a_in; req_len = 16'(len_in); req_swap = sw; req_to_mem = dr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ea = a_in | hi_base;
        el = len_in;
        if (sw) begin ea[0] = 1'b0; el = el & ~1; end
        ch = 64; kb = 0;
        if (el == 0) begin
            chk(done == 1'b1, "R7 zero-length done", 32'(done), 1);
            chk(mem_req == 1'b0, "R7 zero-length no request", 32'(mem_req), 0);
            return;
        end
        chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
        while (el > 0) begin
            off = int'(ea[1:0]);
            n = 4 - off;
            if (el < n) n = el;
            if (sw && dr && ch < n) n = ch;
            ebe = 4'(((1 << n) - 1) << off);
            last = (n == el) || (sw && dr && n == ch);
            pw = 32'h1122_3344 ^ (32'(kb) * 32'h0103_0507);
            pw_data = pw;
            #1;
            chk(mem_req == 1'b1, "R6 beat requested", 32'(mem_req), 1);
            chk(mem_we == dr, "R10 direction", 32'(mem_we), 32'(dr));
            chk(mem_addr == (ea & 32'hFFFF_FFFC), sw ? "R3 beat address" : "R1 beat address",
                mem_addr, ea & 32'hFFFF_FFFC);
            chk(mem_be == ebe, "R6 byte enables", 32'(mem_be), 32'(ebe));
            chk(mem_last == last, "R5 last marker", 32'(mem_last), 32'(last));
            if (dr)
                chk(mem_wdata == (sw ? sw16(pw) : pw), sw ? "R4 write swap" : "R2 write pass",
                    mem_wdata, sw ? sw16(pw) : pw);
            cyc++;
            if ((cyc % 3) == 1) begin
                mem_ready = 1'b0;
                req_addr = 32'h0000_0FF0; req_len = 16'd7; req_valid = 1'b1;
                #1;
                chk(pw_take == 1'b0, "R10 no take on stall", 32'(pw_take), 0);
                @(negedge clk);
                req_valid = 1'b0;
                continue;
            end
            rdv = 32'hC35A_0000 ^ ea ^ (32'(kb) * 32'h0001_0203);
            mem_ready = 1'b1; mem_rdata = rdv;
            #0.5;
            chk(pw_take == dr, "R10 take on accept", 32'(pw_take), 32'(dr));
            @(negedge clk);
            mem_ready = 1'b0;
            if (!dr) begin
                exp_rd = (sw ? sw16(rdv) : rdv) & bmask(ebe);
                chk(rd_valid == 1'b1, "R9 read valid", 32'(rd_valid), 1);
                chk(rd_be == ebe, "R9 read lanes", 32'(rd_be), 32'(ebe));
                chk(rd_data == exp_rd, sw ? "R4 read swap" : "R9 read data", rd_data, exp_rd);
            end
            ea = ea + 32'(n);
            el = el - n;
            if (sw && dr) begin ch = ch - n; if (ch == 0) ch = 64; end
            kb++;
            chk(done == (el == 0), "R7 done timing", 32'(done), 32'(el == 0));
        end
        chk(busy == 1'b0, "R8 idle after done", 32'(busy), 0);
        @(negedge clk);
        chk(mem_req == 1'b0 && done == 1'b0, "R8 stray request ignored", 32'(mem_req), 0);
    endtask

    initial begin
        int lens[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 63, 64, 65, 66, 130};
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_req == 0 && done == 0 && rd_valid == 0, "R8 reset state",
            {28'd0, busy, mem_req, done, rd_valid}, 0);
        rst_n = 1'b1;
        for (int sw = 0; sw < 2; sw++)
            for (int dr = 0; dr < 2; dr++)
                for (int off = 0; off < 8; off++)
                    for (int li = 0; li < 14; li++)
                        run_xfer(32'h0000_1000 + 32'(off), lens[li], sw[0], dr[0]);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule